// File: doc/BRIEF.md
# Page-Mode Frame Buffer Cycle Scheduler

This block turns drawing-engine run requests into a timed sequence of frame buffer memory cycles. A run is either a horizontal span or a vertical vector. It is given as a number of 16-pixel tiles, one memory cycle per tile. For each cycle the scheduler picks a type and decides whether the cycle is full or page-mode. It then holds that cycle for its exact duration in clock ticks, where one clock is one 40 ns tick. A combined screen and RAM refresh cycle falls due on a fixed tick interval. It takes the next cycle slot ahead of any data cycle, and the run that it interrupts restarts its page position.

Requests arrive on a valid/ready port. `req_ready` is high only while no run is in progress. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. The source holds `req_valid` and its fields steady until then, which is its back-pressure. `req_ready` stays low until the clock on which `run_done` pulses. The worst-case ALU class comes from every slice on `slice_class` and is sampled as each cycle is issued. Each issued cycle shows as a one-clock `cyc_strobe`, with its type, its page flag and its length in ticks.

Top module: `fbc_cycle_sched`

## Requirements
- R1: `req_ready` is 1 exactly when no run is active. A request is taken when `req_valid` and `req_ready` are both 1 at a rising edge, and `req_ready` is 0 on the next clock. `run_done` pulses for one clock exactly as many clocks after the last data strobe of the run as that cycle's tick count. `req_ready` is 1 in that same clock.
- R2: A tick is one clock (40 ns). Full cycles last: standard read 8 ticks, standard write 8, read-modify-write 12, between-planes read 10. While work is waiting, each strobe follows the previous one after exactly the previous cycle's tick count.
- R3: `cyc_type` codes: 0 read, 1 write, 2 read-modify-write, 3 between-planes read, 4 refresh. `req_kind` codes: 0 read, 1 write, 2 between-planes read, 3 read. Slice i reports its class in `slice_class[2i+1:2i]`, where 0 means clear, 1 means source and 2 or 3 means read-modify-write. A write becomes type 2 when any one slice reports 2 or 3.
- R4: A horizontal run in page mode needs `req_page_en`=1 and at least 4 tiles. Its first cycle, its second cycle and its last cycle are full, except that a second write lasts 10 ticks. Every cycle in between is page-mode, with `cyc_page`=1: read 4 ticks, write 4, read-modify-write 8, between-planes read 6.
- R5: A horizontal run with fewer than 4 tiles, or with `req_page_en`=0, uses only full cycles with `cyc_page`=0.
- R6: A vertical run with `req_page_en`=1 and `req_four_line`=1 has pages of 4 scan lines. A cycle whose position in the run is a multiple of 4 is full, and lasts 10 ticks if it is a write. The other three cycles of each page are page-mode cycles.
- R7: A vertical run with `req_four_line`=0 (one line per page) or with `req_page_en`=0 uses only full cycles, and its writes last 8 ticks.
- R8: A refresh falls due every 390 clocks, or every 271 clocks when `cfg_alt_refresh`=1. It is issued at the next cycle boundary, ahead of any data cycle, with `cyc_type`=4, 14 ticks and `cyc_page`=0.
- R9: A refresh issued during a run sets the run position back to zero. The next data cycle is then handled as the first cycle of a run, or as the first line of a page.
- R10: A 6-tile horizontal write run in page mode takes 38 clocks, 1.52 us, from its first data strobe to `run_done`.
- R11: A request for 0 tiles ends with `run_done` and issues no data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one 40 ns tick per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_alt_refresh | input | 1 | Selects the shorter refresh interval |
| req_valid | input | 1 | A run request is offered |
| req_ready | output | 1 | Scheduler is free to take a run |
| req_kind | input | 2 | Cycle kind of the run |
| req_tiles | input | 12 | Number of tiles (memory cycles) in the run |
| req_vertical | input | 1 | 1 for a vertical vector, 0 for a horizontal span |
| req_page_en | input | 1 | Page-mode cycles allowed |
| req_four_line | input | 1 | 1: four scan lines per page, 0: one |
| slice_class | input | 8 | Replacement-rule class of each of 4 ALU slices |
| cyc_strobe | output | 1 | One-clock pulse at the start of a cycle |
| cyc_type | output | 3 | Type of the cycle being started |
| cyc_page | output | 1 | The cycle is a page-mode cycle |
| cyc_ticks | output | 5 | Length of the cycle in ticks |
| run_done | output | 1 | One-clock pulse when a run has finished |

## Verification
The first data strobe of a run comes at the earliest one clock after the accepting edge. It is later if a refresh still holds the memory. Each strobe after that comes exactly the previous cycle's tick count later. `run_done` comes exactly the last data cycle's tick count after that cycle's strobe. The bench samples outputs on falling edges and keeps a clock counter. It checks every spacing against the tick count it saw before, and predicts each cycle's type, length and page flag from its own position model. That model sets the position back to zero whenever it sees a refresh strobe in the run. Refresh intervals are measured as the distance between consecutive refresh strobes while idle.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int TICK_NS = 40;
  localparam int TICK_W  = 5;

  localparam int NS_RD_FULL  = 320;
  localparam int NS_RD_PAGE  = 160;
  localparam int NS_WR_FULL  = 320;
  localparam int NS_WR_LONG  = 400;
  localparam int NS_WR_PAGE  = 160;
  localparam int NS_RMW_FULL = 480;
  localparam int NS_RMW_PAGE = 320;
  localparam int NS_BP_FULL  = 400;
  localparam int NS_BP_PAGE  = 240;
  localparam int NS_REFRESH  = 560;
  localparam int NS_REF_STD  = 15625;
  localparam int NS_REF_ALT  = 10851;

  localparam int REF_STD_TICKS = NS_REF_STD / TICK_NS;
  localparam int REF_ALT_TICKS = NS_REF_ALT / TICK_NS;

  typedef enum logic [2:0] {
    CYC_READ    = 3'd0,
    CYC_WRITE   = 3'd1,
    CYC_RMW     = 3'd2,
    CYC_BPREAD  = 3'd3,
    CYC_REFRESH = 3'd4
  } cyc_kind_e;

  function automatic logic [TICK_W-1:0] ns2t(input int ns);
    return TICK_W'(ns / TICK_NS);
  endfunction
endpackage

// File: rtl/fbc_worst_class.sv
module fbc_worst_class #(
  parameter int NSLICE = 4
) (
  input  logic [2*NSLICE-1:0] cls,
  output logic                need_rmw
);
  logic [NSLICE-1:0] hit;

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    assign hit[g] = (cls[2*g +: 2] >= 2'd2);
  end

  assign need_rmw = |hit;
endmodule

// File: rtl/fbc_cycle_len.sv
module fbc_cycle_len
  import fbc_pkg::*;
(
  input  cyc_kind_e         kind,
  input  logic              page,
  input  logic              long_wr,
  output logic [TICK_W-1:0] ticks
);
  always_comb begin
    unique case (kind)
      CYC_READ:   ticks = page ? ns2t(NS_RD_PAGE) : ns2t(NS_RD_FULL);
      CYC_WRITE:  ticks = page ? ns2t(NS_WR_PAGE) :
                          (long_wr ? ns2t(NS_WR_LONG) : ns2t(NS_WR_FULL));
      CYC_RMW:    ticks = page ? ns2t(NS_RMW_PAGE) : ns2t(NS_RMW_FULL);
      CYC_BPREAD: ticks = page ? ns2t(NS_BP_PAGE) : ns2t(NS_BP_FULL);
      default:    ticks = ns2t(NS_REFRESH);
    endcase
  end
endmodule

// File: rtl/fbc_refresh_timer.sv
module fbc_refresh_timer #(
  parameter int STD_TICKS = 390,
  parameter int ALT_TICKS = 271
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alt,
  input  logic take,
  output logic pend
);
  localparam int MAXT  = (STD_TICKS > ALT_TICKS) ? STD_TICKS : ALT_TICKS;
  localparam int REF_W = $clog2(MAXT + 1);

  logic [REF_W-1:0] cnt;
  logic [REF_W-1:0] limit;
  logic             expire;

  assign limit  = alt ? REF_W'(ALT_TICKS - 1) : REF_W'(STD_TICKS - 1);
  assign expire = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      cnt  <= expire ? '0 : cnt + REF_W'(1);
      pend <= (pend & ~take) | expire;
    end
  end

  // Pending refresh is never dropped until the scheduler takes it
  assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !take |=> pend);
endmodule

// File: rtl/fbc_cycle_sched.sv
module fbc_cycle_sched
  import fbc_pkg::*;
#(
  parameter int NSLICE         = 4,
  parameter int CNT_W          = 12,
  parameter int LINES_PER_PAGE = 4,
  parameter int HPM_MIN_TILES  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_alt_refresh,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [CNT_W-1:0]    req_tiles,
  input  logic                req_vertical,
  input  logic                req_page_en,
  input  logic                req_four_line,
  input  logic [2*NSLICE-1:0] slice_class,
  output logic                cyc_strobe,
  output logic [2:0]          cyc_type,
  output logic                cyc_page,
  output logic [TICK_W-1:0]   cyc_ticks,
  output logic                run_done
);
  localparam int LPP_W = $clog2(LINES_PER_PAGE);
  localparam logic [TICK_W-1:0] REF_TICKS = ns2t(NS_REFRESH);

  logic              active;
  logic [1:0]        kind_q;
  logic              vert_q, hpm_q, vpm_q;
  logic [CNT_W-1:0]  left, pos;
  logic [TICK_W-1:0] bc;

  logic              need_rmw, ref_pend;
  cyc_kind_e         eff;
  logic              pg, lw, last_tile;
  logic [TICK_W-1:0] data_ticks;
  logic              take_ref, data_go, finish;

  fbc_worst_class #(.NSLICE(NSLICE)) u_worst (
    .cls(slice_class), .need_rmw(need_rmw));

  fbc_refresh_timer #(.STD_TICKS(REF_STD_TICKS), .ALT_TICKS(REF_ALT_TICKS)) u_ref (
    .clk(clk), .rst_n(rst_n), .alt(cfg_alt_refresh), .take(take_ref), .pend(ref_pend));

  fbc_cycle_len u_len (.kind(eff), .page(pg), .long_wr(lw), .ticks(data_ticks));

  assign req_ready = !active;
  assign last_tile = (left == CNT_W'(1));
  assign take_ref  = (bc == '0) && ref_pend;
  assign data_go   = (bc == '0) && !ref_pend && active && (left != '0);
  assign finish    = (bc == '0) && active && (left == '0);

  always_comb begin
    unique case (kind_q)
      2'd1:    eff = need_rmw ? CYC_RMW : CYC_WRITE;
      2'd2:    eff = CYC_BPREAD;
      default: eff = CYC_READ;
    endcase
    if (vert_q) begin
      pg = vpm_q && (pos[LPP_W-1:0] != '0);
      lw = vpm_q && (pos[LPP_W-1:0] == '0) && (eff == CYC_WRITE);
    end else begin
      pg = hpm_q && (pos >= CNT_W'(2)) && !last_tile;
      lw = hpm_q && (pos == CNT_W'(1)) && !last_tile && (eff == CYC_WRITE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      kind_q     <= 2'd0;
      vert_q     <= 1'b0;
      hpm_q      <= 1'b0;
      vpm_q      <= 1'b0;
      left       <= '0;
      pos        <= '0;
      bc         <= '0;
      cyc_strobe <= 1'b0;
      cyc_type   <= CYC_READ;
      cyc_page   <= 1'b0;
      cyc_ticks  <= '0;
      run_done   <= 1'b0;
    end else begin
      cyc_strobe <= 1'b0;
      run_done   <= 1'b0;
      if (bc != '0) bc <= bc - TICK_W'(1);
      if (take_ref) begin
        cyc_strobe <= 1'b1;
        cyc_type   <= CYC_REFRESH;
        cyc_ticks  <= REF_TICKS;
        cyc_page   <= 1'b0;
        bc         <= REF_TICKS - TICK_W'(1);
        pos        <= '0;
      end else if (data_go) begin
        cyc_strobe <= 1'b1;
        cyc_type   <= eff;
        cyc_ticks  <= data_ticks;
        cyc_page   <= pg;
        bc         <= data_ticks - TICK_W'(1);
        pos        <= pos + CNT_W'(1);
        left       <= left - CNT_W'(1);
      end
      if (finish) begin
        run_done <= 1'b1;
        active   <= 1'b0;
      end
      if (!active && req_valid) begin
        active <= 1'b1;
        kind_q <= req_kind;
        vert_q <= req_vertical;
        hpm_q  <= req_page_en && (req_tiles >= CNT_W'(HPM_MIN_TILES));
        vpm_q  <= req_page_en && req_four_line;
        left   <= req_tiles;
        pos    <= '0;
      end
    end
  end

  // Observation state for the timing properties
  logic       prev_ref, seen;
  logic [7:0] gap;
  logic [TICK_W-1:0] last_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ref <= 1'b0;
      seen     <= 1'b0;
      gap      <= '0;
      last_len <= '0;
    end else if (cyc_strobe) begin
      prev_ref <= (cyc_type == CYC_REFRESH);
      seen     <= 1'b1;
      gap      <= 8'd1;
      last_len <= cyc_ticks;
    end else if (gap != 8'hff) begin
      gap <= gap + 8'd1;
    end
  end

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe && seen |-> gap >= {{(8-TICK_W){1'b0}}, last_len});

  assert_page_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe && cyc_page |-> cyc_ticks <= TICK_W'(8));

  assert_refresh_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe && (cyc_type == CYC_REFRESH) |-> (cyc_ticks == REF_TICKS) && !cyc_page);

  assert_restart_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe && prev_ref |-> !cyc_page);
endmodule

// File: tb/sim_fbc_cycle_sched.sv
module sim_fbc_cycle_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_alt_refresh = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'd0;
  logic [11:0] req_tiles = '0;
  logic        req_vertical = 1'b0;
  logic        req_page_en = 1'b0;
  logic        req_four_line = 1'b0;
  logic [7:0]  slice_class = '0;
  logic        cyc_strobe;
  logic [2:0]  cyc_type;
  logic        cyc_page;
  logic [4:0]  cyc_ticks;
  logic        run_done;

  int nchk = 0;
  int nerr = 0;
  int cyc_n = 0;
  bit ended = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc_n <= cyc_n + 1;

  fbc_cycle_sched u0 (
    .clk(clk), .rst_n(rst_n), .cfg_alt_refresh(cfg_alt_refresh),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_tiles(req_tiles), .req_vertical(req_vertical), .req_page_en(req_page_en),
    .req_four_line(req_four_line), .slice_class(slice_class),
    .cyc_strobe(cyc_strobe), .cyc_type(cyc_type), .cyc_page(cyc_page),
    .cyc_ticks(cyc_ticks), .run_done(run_done));

  task automatic chk_eq(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void exp_cyc(input int kind, input bit rmw, input bit vert,
      input bit hpm, input bit vpm, input int pos, input int rem,
      output int t, output int len, output bit pg);
    int full, pgl;
    bit lw;
    t = (kind == 1) ? (rmw ? 2 : 1) : (kind == 2) ? 3 : 0;
    full = (t == 2) ? 12 : (t == 3) ? 10 : 8;
    pgl  = (t == 2) ? 8  : (t == 3) ? 6  : 4;
    if (vert) begin
      pg = vpm && (pos % 4) != 0;
      lw = vpm && (pos % 4) == 0 && t == 1;
    end else begin
      pg = hpm && pos >= 2 && rem != 1;
      lw = hpm && pos == 1 && rem != 1 && t == 1;
    end
    len = pg ? pgl : (lw ? 10 : full);
  endfunction

  task automatic sync_ref();
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (cyc_strobe && cyc_type == 3'd4) return;
    end
    chk_eq("R8", "refresh seen while waiting", 0, 1);
  endtask

  task automatic run_req(input int kind, input int tiles, input bit vert, input bit pm,
      input bit four, input logic [7:0] cls, input string tag,
      output int total, output int nref, output int ndata);
    bit rmw = 0, fin = 0, have_prev = 0, pg;
    int pos = 0, rem = tiles, first_t = -1, prev_t = 0, prev_len = 0;
    int ld_t = 0, ld_len = 0, t, len;
    bit hpm = pm && tiles >= 4;
    bit vpm = pm && four;
    for (int i = 0; i < 4; i++) if (cls[2*i +: 2] >= 2) rmw = 1;
    total = 0; nref = 0; ndata = 0;
    @(negedge clk);
    slice_class = cls; req_kind = 2'(kind); req_tiles = 12'(tiles);
    req_vertical = vert; req_page_en = pm; req_four_line = four;
    req_valid = 1'b1;
    chk_eq("R1", "ready before request", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R1", "ready low after accept", int'(req_ready), 0);
    for (int k = 0; k < 5000 && !fin; k++) begin
      if (cyc_strobe) begin
        if (have_prev) chk_eq("R2", "strobe spacing", cyc_n - prev_t, prev_len);
        if (cyc_type == 3'd4) begin
          nref++;
          chk_eq("R8", "refresh ticks", int'(cyc_ticks), 14);
          chk_eq("R8", "refresh page flag", int'(cyc_page), 0);
          pos = 0;
        end else begin
          exp_cyc(kind, rmw, vert, hpm, vpm, pos, rem, t, len, pg);
          chk_eq("R3", $sformatf("%s type at pos %0d", tag, pos), int'(cyc_type), t);
          chk_eq(tag, $sformatf("ticks at pos %0d", pos), int'(cyc_ticks), len);
          chk_eq(tag, $sformatf("page flag at pos %0d", pos), int'(cyc_page), int'(pg));
          if (first_t < 0) first_t = cyc_n;
          ndata++; pos++; rem--;
          ld_t = cyc_n; ld_len = int'(cyc_ticks);
        end
        prev_t = cyc_n; prev_len = int'(cyc_ticks); have_prev = 1;
      end
      if (run_done) begin
        fin = 1;
        chk_eq("R1", "tiles left at done", rem, 0);
        if (ndata > 0) chk_eq("R1", "done after last duration", cyc_n - ld_t, ld_len);
        chk_eq("R1", "ready with done", int'(req_ready), 1);
        total = (first_t < 0) ? 0 : cyc_n - first_t;
      end
      if (!fin) @(negedge clk);
    end
    if (!fin) chk_eq(tag, "run finished", 0, 1);
  endtask

  task automatic t_reset();
    chk_eq("R1", "reset ready", int'(req_ready), 1);
    chk_eq("R1", "reset strobe", int'(cyc_strobe), 0);
    chk_eq("R1", "reset done", int'(run_done), 0);
  endtask

  task automatic t_span6();
    int tot, nr, nd;
    sync_ref();
    run_req(1, 6, 0, 1, 0, 8'h55, "R4", tot, nr, nd);
    chk_eq("R10", "refreshes inside span", nr, 0);
    chk_eq("R10", "data cycles", nd, 6);
    chk_eq("R10", "span time ns", tot * 40, 1520);
  endtask

  task automatic t_full_only();
    int tot, nr, nd;
    sync_ref();
    run_req(0, 3, 0, 1, 0, 8'h00, "R5", tot, nr, nd);
    chk_eq("R5", "short read time", tot, 24);
    run_req(1, 6, 0, 0, 0, 8'h55, "R5", tot, nr, nd);
    chk_eq("R5", "no-page write time", tot, 48);
  endtask

  task automatic t_rmw();
    int tot, nr, nd;
    sync_ref();
    run_req(1, 5, 0, 1, 0, 8'h20, "R3", tot, nr, nd);
    chk_eq("R3", "rmw span time", tot, 52);
    run_req(1, 4, 1, 0, 0, 8'hC0, "R3", tot, nr, nd);
    chk_eq("R3", "rmw vertical time", tot, 48);
  endtask

  task automatic t_bp();
    int tot, nr, nd;
    sync_ref();
    run_req(2, 5, 0, 1, 0, 8'h00, "R4", tot, nr, nd);
    chk_eq("R4", "between-planes span time", tot, 42);
  endtask

  task automatic t_vert();
    int tot, nr, nd;
    sync_ref();
    run_req(1, 8, 1, 1, 1, 8'h55, "R6", tot, nr, nd);
    chk_eq("R6", "vertical write time", tot, 44);
    run_req(1, 6, 1, 1, 0, 8'h55, "R7", tot, nr, nd);
    chk_eq("R7", "one-line page time", tot, 48);
    run_req(0, 5, 1, 0, 1, 8'h00, "R7", tot, nr, nd);
    chk_eq("R7", "no-page vertical time", tot, 40);
  endtask

  task automatic t_restart();
    int tot, nr, nd;
    sync_ref();
    repeat (300) @(negedge clk);
    run_req(1, 27, 1, 1, 1, 8'h55, "R9", tot, nr, nd);
    chk_eq("R9", "refresh during vertical run", nr, 1);
    sync_ref();
    repeat (300) @(negedge clk);
    run_req(1, 40, 0, 1, 0, 8'h55, "R9", tot, nr, nd);
    chk_eq("R9", "refresh during span", nr, 1);
  endtask

  task automatic t_zero();
    int tot, nr, nd;
    sync_ref();
    run_req(0, 0, 0, 1, 0, 8'h00, "R11", tot, nr, nd);
    chk_eq("R11", "data cycles for empty run", nd, 0);
  endtask

  task automatic t_period();
    int t0;
    sync_ref();
    t0 = cyc_n;
    sync_ref();
    chk_eq("R8", "standard interval", cyc_n - t0, 390);
    cfg_alt_refresh = 1'b1;
    sync_ref();
    sync_ref();
    t0 = cyc_n;
    sync_ref();
    chk_eq("R8", "alternate interval", cyc_n - t0, 271);
    cfg_alt_refresh = 1'b0;
    sync_ref();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_span6();
    t_full_only();
    t_rmw();
    t_bp();
    t_vert();
    t_restart();
    t_zero();
    t_period();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      chk_eq("R1", "watchdog expired", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule